// File: doc/BRIEF.md
# Burst Address Sequencer with Dual Strobes

This block produces the word address for a synchronous burst memory port. A new external address is taken in whenever one of two active-low address strobes is accepted on a rising clock edge. One strobe belongs to the processor and one to the memory controller. The two lowest address bits become the start position of a 4-beat burst. After that, an active-low advance input steps the burst position one beat per clock. A static order input picks the burst order. When low, the low bits count upward modulo 4 and wrap inside the aligned 4-word block. When high, the low bits are the start bits XORed with a beat count.

The block also keeps a selected/deselected flag. Three chip enables set this flag, but only on cycles that load a new address. The flag is held in a two-state machine with the states DESEL and ACTIVE. These transitions exist:
- LOAD_SEL moves DESEL to ACTIVE on a load with all enables active.
- LOAD_DESEL moves ACTIVE to DESEL on a load with any enable inactive.
- A load that leaves the selection unchanged keeps the current state.
- HOLD keeps the state when there is no load.

The beat counter steps only in ACTIVE.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `addr_out` is 0 and `sel` is 0 (state DESEL).
- R2: When `ctl_stb_n` is sampled low, the next `addr_out` equals the sampled `addr_in`, whatever `ce1_n` is.
- R3: When `cpu_stb_n` and `ce1_n` are both sampled low, the next `addr_out` equals the sampled `addr_in`.
- R4: When `cpu_stb_n` is sampled low with `ce1_n` high and `ctl_stb_n` high, no load happens: `addr_out` and `sel` hold.
- R5: When both strobes are sampled low with `ce1_n` low, exactly one load of `addr_in` happens, and the burst restarts at its start bits.
- R6: On a load cycle, the next `sel` is 1 only if `ce1_n`=0, `ce2`=1 and `ce3_n`=0; otherwise it is 0.
- R7: On cycles without a load, changes on the chip enables leave `sel` unchanged.
- R8: With `order`=0 and `sel`=1, each cycle with `adv_n` low and no load adds 1 modulo 4 to `addr_out[1:0]`. Bits above bit 1 stay unchanged.
- R9: With `order`=1, `addr_out[1:0]` equals the loaded start bits XORed with a beat count. The count is 0 at load and rises by 1 modulo 4 per accepted advance. For start 1 the sequence is 1, 0, 3, 2.
- R10: With no load and `adv_n` high, `addr_out` holds.
- R11: While `sel` is 0, `adv_n` low has no effect: `addr_out` holds.
- R12: A load in the same cycle as `adv_n` low takes priority, so the next `addr_out` equals `addr_in` exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_stb_n | input | 1 | Processor address strobe, active low, gated by `ce1_n` |
| ctl_stb_n | input | 1 | Controller address strobe, active low, ungated |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3_n | input | 1 | Chip enable 3, active low |
| order | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| addr_in | input | ADDR_W | External address |
| addr_out | output | ADDR_W | Current word address |
| sel | output | 1 | Device selected flag |

## Verification
Every register in this block reaches the ports within one clock. A bad state flag shows on `sel` on the cycle after the load that set it, and it also freezes or releases the burst on the next advance. A wrong beat count or a wrong start register shows on `addr_out[1:0]` right after the next advance, and the pattern reveals it. In linear order a bad count breaks the +1 step. In interleaved order the XOR pattern breaks, which the 1, 0, 3, 2 walk exposes. A wrong base register shows in the upper bits on the very cycle after the load.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
    typedef enum logic {
        ST_DESEL  = 1'b0,
        ST_ACTIVE = 1'b1
    } seq_state_t;

    typedef enum logic [1:0] {
        LD_NONE = 2'd0,
        LD_CPU  = 2'd1,
        LD_CTL  = 2'd2
    } load_src_t;
endpackage

// File: rtl/strobe_arbiter.sv
module strobe_arbiter
    import burst_seq_pkg::*;
(
    input  logic      cpu_stb_n,
    input  logic      ctl_stb_n,
    input  logic      ce1_n,
    output load_src_t src
);
    // processor strobe wins when both are low, but only counts while ce1_n is low
    always_comb begin
        if (!cpu_stb_n && !ce1_n)
            src = LD_CPU;
        else if (!ctl_stb_n)
            src = LD_CTL;
        else
            src = LD_NONE;
    end
endmodule

// File: rtl/beat_counter.sv
module beat_counter #(
    parameter int BB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    output logic [BB-1:0] beat
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            beat <= '0;
        else if (clear)
            beat <= '0;
        else if (step)
            beat <= beat + 1'b1;
    end
endmodule

// File: rtl/order_map.sv
module order_map #(
    parameter int BB = 2
) (
    input  logic [BB-1:0] start,
    input  logic [BB-1:0] beat,
    input  logic          interleave,
    output logic [BB-1:0] low
);
    always_comb begin
        if (interleave)
            low = start ^ beat;
        else
            low = start + beat;
    end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int BURST_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_stb_n,
    input  logic              ctl_stb_n,
    input  logic              adv_n,
    input  logic              ce1_n,
    input  logic              ce2,
    input  logic              ce3_n,
    input  logic              order,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic              sel
);
    localparam int HI_W = ADDR_W - BURST_BITS;

    seq_state_t            state, state_nxt;
    load_src_t             src;
    logic                  load;
    logic                  ce_ok;
    logic                  step;
    logic [HI_W-1:0]       base_hi;
    logic [BURST_BITS-1:0] start_low;
    logic [BURST_BITS-1:0] beat;
    logic [BURST_BITS-1:0] low;

    strobe_arbiter u_arb (
        .cpu_stb_n (cpu_stb_n),
        .ctl_stb_n (ctl_stb_n),
        .ce1_n     (ce1_n),
        .src       (src)
    );

    // next-state logic and burst step qualification
    always_comb begin
        ce_ok     = !ce1_n && ce2 && !ce3_n;
        load      = 1'b0;
        state_nxt = state;
        unique case (src)
            LD_CPU, LD_CTL: load = 1'b1;
            default:        load = 1'b0;
        endcase
        unique case (state)
            ST_DESEL:  if (load && ce_ok)  state_nxt = ST_ACTIVE;  // LOAD_SEL
            ST_ACTIVE: if (load && !ce_ok) state_nxt = ST_DESEL;   // LOAD_DESEL
            default:   state_nxt = ST_DESEL;
        endcase
        step = (state == ST_ACTIVE) && !load && !adv_n;
    end

    // state and address registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_DESEL;
            base_hi   <= '0;
            start_low <= '0;
        end else begin
            state <= state_nxt;
            if (load) begin
                base_hi   <= addr_in[ADDR_W-1:BURST_BITS];
                start_low <= addr_in[BURST_BITS-1:0];
            end
        end
    end

    beat_counter #(.BB(BURST_BITS)) u_beat (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (load),
        .step  (step),
        .beat  (beat)
    );

    order_map #(.BB(BURST_BITS)) u_map (
        .start      (start_low),
        .beat       (beat),
        .interleave (order),
        .low        (low)
    );

    // outputs
    always_comb begin
        addr_out = {base_hi, low};
        sel      = (state == ST_ACTIVE);
    end
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
    parameter int ADDR_W     = 17,
    parameter int BURST_BITS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_stb_n,
    input logic              ctl_stb_n,
    input logic              adv_n,
    input logic              ce1_n,
    input logic              ce2,
    input logic              ce3_n,
    input logic              order,
    input logic [ADDR_W-1:0] addr_in,
    input logic [ADDR_W-1:0] addr_out,
    input logic              sel
);
    localparam int BB = BURST_BITS;

    logic ld_seen;
    assign ld_seen = (!cpu_stb_n && !ce1_n) || !ctl_stb_n;

    a_r2_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_stb_n |=> addr_out == $past(addr_in));

    a_r3_cpu_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_stb_n && !ce1_n) |=> addr_out == $past(addr_in));

    a_r4_cpu_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_stb_n && ce1_n && ctl_stb_n && adv_n)
        |=> (order != $past(order)) || ($stable(addr_out) && $stable(sel)));

    a_r6_select: assert property (@(posedge clk) disable iff (!rst_n)
        ld_seen |=> sel == $past(!ce1_n && ce2 && !ce3_n));

    a_r7_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_seen |=> $stable(sel));

    a_r8_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !adv_n && !ld_seen && !order)
        |=> order || ((addr_out[BB-1:0] == BB'($past(addr_out[BB-1:0]) + 1'b1))
             && (addr_out[ADDR_W-1:BB] == $past(addr_out[ADDR_W-1:BB]))));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_seen && adv_n) |=> (order != $past(order)) || $stable(addr_out));

    a_r11_desel_adv: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel && !ld_seen) |=> (order != $past(order)) || $stable(addr_out));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(
    .ADDR_W     (ADDR_W),
    .BURST_BITS (BURST_BITS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_stb_n (cpu_stb_n),
    .ctl_stb_n (ctl_stb_n),
    .adv_n     (adv_n),
    .ce1_n     (ce1_n),
    .ce2       (ce2),
    .ce3_n     (ce3_n),
    .order     (order),
    .addr_in   (addr_in),
    .addr_out  (addr_out),
    .sel       (sel)
);

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cpu_stb_n, ctl_stb_n, adv_n;
    logic          ce1_n, ce2, ce3_n, order;
    logic [AW-1:0] addr_in;
    logic [AW-1:0] addr_out;
    logic          sel;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2 clk = ~clk;  // 4 ns period

    burst_addr_seq #(.ADDR_W(AW), .BURST_BITS(2)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n),
        .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .order(order),
        .addr_in(addr_in), .addr_out(addr_out), .sel(sel)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        cpu_stb_n = 1'b1; ctl_stb_n = 1'b1; adv_n = 1'b1;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic ce_on();
        ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; idle(); ce1_n = 1'b1; ce2 = 1'b0; ce3_n = 1'b1;
        order = 1'b0; addr_in = '0;
        tick(); tick();
        rst_n = 1'b1;
        check("R1 addr", addr_out, 0);
        check("R1 sel", sel, 0);
    endtask

    task automatic t_ctl_load();
        ce1_n = 1'b1; ce2 = 1'b1; ce3_n = 1'b0; addr_in = 17'h1ABCD; ctl_stb_n = 1'b0;
        tick(); idle();
        check("R2 ctl load ce1 high", addr_out, 17'h1ABCD);
        check("R6 deselect on ce1 high", sel, 0);
        ce_on(); addr_in = 17'h0BCDE; ctl_stb_n = 1'b0;
        tick(); idle();
        check("R2 ctl load", addr_out, 17'h0BCDE);
        check("R6 select", sel, 1);
    endtask

    task automatic t_cpu_gate();
        ce1_n = 1'b1; addr_in = 17'h00111; cpu_stb_n = 1'b0;
        tick(); idle();
        check("R4 gated addr", addr_out, 17'h0BCDE);
        check("R4 gated sel", sel, 1);
        ce_on(); addr_in = 17'h00222; cpu_stb_n = 1'b0;
        tick(); idle();
        check("R3 cpu load", addr_out, 17'h00222);
    endtask

    task automatic t_both();
        ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0; adv_n = 1'b0;
        tick(); idle();
        check("R8 step before both", addr_out, 17'h00223);
        ce2 = 1'b0; addr_in = 17'h1F3F2; cpu_stb_n = 1'b0; ctl_stb_n = 1'b0;
        tick(); idle();
        check("R5 both load", addr_out, 17'h1F3F2);
        check("R6 ce2 low deselect", sel, 0);
        ce2 = 1'b1;
        tick();
        check("R7 sel stays 0", sel, 0);
        adv_n = 1'b0;
        tick(); tick(); idle();
        check("R11 no advance deselected", addr_out, 17'h1F3F2);
        ce3_n = 1'b1; ctl_stb_n = 1'b0; addr_in = 17'h05550;
        tick(); idle(); ce_on();
        check("R6 ce3 high deselect", sel, 0);
        ctl_stb_n = 1'b0;
        tick(); idle();
        check("R6 reselect", sel, 1);
        ce1_n = 1'b1; ce2 = 1'b0; ce3_n = 1'b1;
        tick();
        check("R7 sel stays 1", sel, 1);
    endtask

    task automatic t_linear();
        order = 1'b0; ce_on(); addr_in = 17'h0F0A6; ctl_stb_n = 1'b0;
        tick(); idle();
        for (int k = 1; k <= 5; k++) begin
            adv_n = 1'b0;
            tick();
            check("R8 linear wrap", addr_out, {15'(17'h0F0A6 >> 2), 2'((2 + k) % 4)});
        end
        adv_n = 1'b1;
        tick(); tick();
        check("R10 hold", addr_out, {15'(17'h0F0A6 >> 2), 2'd3});
    endtask

    task automatic t_inter();
        order = 1'b1; ce_on(); addr_in = 17'h12345; ctl_stb_n = 1'b0;
        tick(); idle();
        check("R9 start", addr_out, 17'h12345);
        for (int k = 1; k <= 4; k++) begin
            adv_n = 1'b0;
            tick();
            check("R9 interleave", addr_out, {15'(17'h12345 >> 2), 2'(1 ^ (k % 4))});
        end
        idle();
    endtask

    task automatic t_load_over_adv();
        order = 1'b1; ce_on(); adv_n = 1'b0;
        tick();
        addr_in = 17'h0AAAB; cpu_stb_n = 1'b0;
        tick(); cpu_stb_n = 1'b1;
        check("R12 load wins", addr_out, 17'h0AAAB);
        tick(); idle();
        check("R12 restart beat", addr_out, 17'h0AAAA);
    endtask

    initial begin
        t_reset();
        t_ctl_load();
        t_cpu_gate();
        t_both();
        t_linear();
        t_inter();
        t_load_over_adv();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #40000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule